// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block collects eight interrupt request pins and presents one interrupt line to a processor. Each pin can be set to latch on a rising edge or to follow its level. Pending requests are held in a request register and filtered by a mask register. Requests being serviced are held in an in-service register. A rotating priority resolver scans the lines starting from a 3-bit base that software can move. The output is raised only when the best unmasked request outranks everything that is already in service.

Software reaches the block through a byte-wide port with a 2-bit address. Address 0 takes setup-start and command bytes and returns status. Address 1 takes setup bytes during setup, loads the mask in normal operation, and returns the mask. Address 2 holds the per-pin trigger mode. A setup sequence is walked by a small state machine with these states: `ST_RUN` (normal operation), `ST_VEC` (waiting for the vector byte), `ST_LINK` (waiting for the link byte, which is accepted and discarded) and `ST_MODE` (waiting for the mode byte). The transitions are:
- start: any state to `ST_VEC`, on a setup-start write.
- vec_to_link: `ST_VEC` to `ST_LINK` when not single.
- vec_to_mode: `ST_VEC` to `ST_MODE` when single and the mode byte is wanted.
- vec_to_run: `ST_VEC` to `ST_RUN` when single and the mode byte is not wanted.
- link_to_mode: `ST_LINK` to `ST_MODE` when the mode byte is wanted.
- link_to_run: `ST_LINK` to `ST_RUN` otherwise.
- mode_to_run: `ST_MODE` to `ST_RUN` after the mode byte.

The processor acknowledges with a one-cycle strobe. While the strobe is high it reads the vector of the winning line. The acknowledge takes effect on the clock edge that ends the strobe.

Top module: `prio_intc`

## Requirements
- R1: Bit n of the trigger register (address 2) set to 1 makes pin n level sensitive: its request bit follows the pin one clock later. Set to 0, the pin is edge sensitive: the request bit is set one clock after a low-to-high transition and is not set again while the pin stays high.
- R2: Candidate lines are ranked in the order base, base+1, ... modulo 8, and the first pending unmasked line wins.
- R3: `irq_out` is high only when an unmasked request exists whose rank is strictly better than the best in-service line's rank. A masked line never raises it.
- R4: `ack_vector` equals {vector base[7:3], winning line}, or {vector base, 7} when nothing wins. The acknowledge clears the winner's request bit only when the winner is edge sensitive, and sets its in-service bit unless auto-EOI is on. An acknowledge with no winner changes nothing.
- R5: With auto-EOI on, an acknowledge leaves the in-service register unchanged. If rotate-on-auto-EOI is also on, the base becomes (acknowledged line + 1) mod 8.
- R6: A write to address 0 with bit 4 set starts setup. It clears the mask, in-service, request and base registers, auto-EOI, rotate-on-auto-EOI, read select and poll, and it enters `ST_VEC`. Bit 0 of that byte requests the mode byte and bit 1 marks single, which skips the link byte. The vector byte gives the vector base from bits 7..3. The mode byte sets auto-EOI from bit 1.
- R7: A write to address 0 with bit 4 clear and bit 3 set is a select byte. Bit 0 chooses what an address-0 read returns (1 = in-service register, 0 = request register). Bit 2 arms a poll for the next read.
- R8: The next read of address 0 or 1 after a poll is armed returns 0x80 | winning line and acknowledges that line as in R4. With no winner it returns 0x07. The poll then disarms.
- R9: A write to address 0 with bits 4 and 3 clear is a command byte with its code in bits 7..5. Code 1 clears the best-ranked in-service bit. Code 3 clears the in-service bit named by bits 2..0. Code 2 has no effect.
- R10: Code 5 acts as code 1 and also sets the base to that line + 1. Code 7 acts as code 3 and also sets the base to line + 1. Code 6 sets the base to (bits 2..0 + 1) mod 8. Codes 0 and 4 clear and set rotate-on-auto-EOI.
- R11: In `ST_RUN`, a write to address 1 loads the mask register and `irq_out` is re-evaluated in the following cycle. A read of address 1 returns the mask.
- R12: After reset the registers are zero, `irq_out` is low, the state is `ST_RUN` and `ack_vector` reads 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request pins |
| cmd_we | input | 1 | Register write strobe |
| cmd_re | input | 1 | Register read strobe (drives poll side effects) |
| cmd_addr | input | 2 | Register address |
| cmd_wdata | input | 8 | Write data |
| cmd_rdata | output | 8 | Read data, combinational |
| irq_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge strobe |
| ack_vector | output | 8 | Vector of the current winner |

## Verification
The resolver is driven with the same pair of pending lines under several bases, so that the winner moves only when the rotation does. The same pair is then tried under a mask, under a full mask, and with mixed edge and level pins, which separates rotation from masking. Nesting is exercised by raising a lower-ranked and then a higher-ranked line while one is in service, so that "strictly better" can be told apart from "any pending". The rotating commands, auto-EOI rotation and poll are each followed by a further request pattern whose winner depends on the new base.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_VEC,
        ST_LINK,
        ST_MODE
    } setup_state_t;

    typedef enum logic [2:0] {
        OP_ROT_AUTO_CLR = 3'd0,
        OP_EOI          = 3'd1,
        OP_NOP          = 3'd2,
        OP_SPEC_EOI     = 3'd3,
        OP_ROT_AUTO_SET = 3'd4,
        OP_ROT_EOI      = 3'd5,
        OP_SET_BASE     = 3'd6,
        OP_ROT_SPEC_EOI = 3'd7
    } op_code_t;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_TRIG = 2'd2;

endpackage

// File: rtl/intc_pin_latch.sv
module intc_pin_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic level_mode,
    input  logic ack_clr,
    input  logic init_clr,
    output logic req
);
    logic last;
    logic rise;

    assign rise = pin && !last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req  <= 1'b0;
            last <= 1'b0;
        end else if (init_clr) begin
            req  <= 1'b0;
            last <= 1'b0;
        end else begin
            last <= pin;
            if (level_mode)
                req <= pin;
            else if (rise)
                req <= 1'b1;
            else if (ack_clr)
                req <= 1'b0;
        end
    end

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !init_clr) |=> (req == $past(pin))); // R1
    AST_EDGE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !init_clr && !rise && !req) |=> !req); // R1
    AST_EDGE_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !init_clr && ack_clr && !rise) |=> !req); // R4

endmodule

// File: rtl/intc_prio_resolve.sv
module intc_prio_resolve #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] bits,
    input  logic [W-1:0] base,
    output logic         found,
    output logic [W-1:0] line,
    output logic [W-1:0] rank
);
    logic [W-1:0] idx;

    // Scan from the worst rank to the best so the best match is written last.
    always_comb begin
        found = 1'b0;
        line  = '0;
        rank  = '0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = base + W'(k);
            if (bits[idx]) begin
                found = 1'b1;
                line  = idx;
                rank  = W'(k);
            end
        end
    end

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
    import intc_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int W = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic          cmd_re,
    input  logic [1:0]    cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          ack,
    input  logic [N-1:0]  irr,
    input  logic          win_valid,
    input  logic [W-1:0]  win_line,
    input  logic          isr_found,
    input  logic [W-1:0]  isr_line,
    output logic [N-1:0]  imr,
    output logic [N-1:0]  isr,
    output logic [N-1:0]  trig,
    output logic [W-1:0]  base,
    output logic [DW-W-1:0] vec_base,
    output logic          read_sel,
    output logic          poll_armed,
    output logic          init_clr,
    output logic [N-1:0]  ack_clr
);
    setup_state_t state, state_nxt;

    logic need_mode, single, auto_eoi, rot_auto;
    logic wr_cmd, wr_data, setup_start, sel_word, op_word;
    logic poll_rd, ack_fire;
    op_code_t op;
    logic [W-1:0] arg_line;

    assign wr_cmd      = cmd_we && (cmd_addr == ADDR_CMD);
    assign wr_data     = cmd_we && (cmd_addr == ADDR_DATA);
    assign setup_start = wr_cmd && cmd_wdata[4];
    assign sel_word    = wr_cmd && !cmd_wdata[4] && cmd_wdata[3];
    assign op_word     = wr_cmd && !cmd_wdata[4] && !cmd_wdata[3];
    assign op          = op_code_t'(cmd_wdata[7:5]);
    assign arg_line    = cmd_wdata[W-1:0];

    assign poll_rd  = cmd_re && !cmd_we && poll_armed &&
                      ((cmd_addr == ADDR_CMD) || (cmd_addr == ADDR_DATA));
    assign ack_fire = (ack || poll_rd) && !cmd_we && win_valid;

    assign init_clr = setup_start;

    always_comb begin
        ack_clr = '0;
        if (ack_fire)
            ack_clr[win_line] = 1'b1;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= state_nxt;
    end

    // Next state: setup sequence.
    always_comb begin
        state_nxt = state;
        if (setup_start) begin
            state_nxt = ST_VEC;
        end else if (wr_data) begin
            unique case (state)
                ST_RUN:  state_nxt = ST_RUN;
                ST_VEC:  state_nxt = !single ? ST_LINK : (need_mode ? ST_MODE : ST_RUN);
                ST_LINK: state_nxt = need_mode ? ST_MODE : ST_RUN;
                ST_MODE: state_nxt = ST_RUN;
            endcase
        end
    end

    // Register updates driven by the state and the decoded strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr        <= '0;
            isr        <= '0;
            trig       <= '0;
            base       <= '0;
            vec_base   <= '0;
            need_mode  <= 1'b0;
            single     <= 1'b0;
            auto_eoi   <= 1'b0;
            rot_auto   <= 1'b0;
            read_sel   <= 1'b0;
            poll_armed <= 1'b0;
        end else begin
            if (cmd_we && (cmd_addr == ADDR_TRIG))
                trig <= cmd_wdata[N-1:0];

            if (setup_start) begin
                imr        <= '0;
                isr        <= '0;
                base       <= '0;
                auto_eoi   <= 1'b0;
                rot_auto   <= 1'b0;
                read_sel   <= 1'b0;
                poll_armed <= 1'b0;
                need_mode  <= cmd_wdata[0];
                single     <= cmd_wdata[1];
            end else begin
                if (poll_rd)
                    poll_armed <= 1'b0;

                if (ack_fire) begin
                    if (!auto_eoi)
                        isr[win_line] <= 1'b1;
                    else if (rot_auto)
                        base <= win_line + W'(1);
                end

                if (wr_data) begin
                    unique case (state)
                        ST_RUN:  imr      <= cmd_wdata[N-1:0];
                        ST_VEC:  vec_base <= cmd_wdata[DW-1:W];
                        ST_LINK: ;
                        ST_MODE: auto_eoi <= cmd_wdata[1];
                    endcase
                end

                if (sel_word) begin
                    read_sel   <= cmd_wdata[0];
                    poll_armed <= cmd_wdata[2];
                end

                if (op_word) begin
                    unique case (op)
                        OP_ROT_AUTO_CLR: rot_auto <= 1'b0;
                        OP_ROT_AUTO_SET: rot_auto <= 1'b1;
                        OP_NOP:          ;
                        OP_EOI: begin
                            if (isr_found)
                                isr[isr_line] <= 1'b0;
                        end
                        OP_ROT_EOI: begin
                            if (isr_found) begin
                                isr[isr_line] <= 1'b0;
                                base          <= isr_line + W'(1);
                            end
                        end
                        OP_SPEC_EOI:     isr[arg_line] <= 1'b0;
                        OP_ROT_SPEC_EOI: begin
                            isr[arg_line] <= 1'b0;
                            base          <= arg_line + W'(1);
                        end
                        OP_SET_BASE:     base <= arg_line + W'(1);
                    endcase
                end
            end
        end
    end

    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (irr[win_line] && !imr[win_line])); // R2
    AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !auto_eoi) |=> isr[$past(win_line)]); // R4
    AST_ISR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && !ack_fire) |=> $stable(isr)); // R4
    AST_AUTO_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && auto_eoi && rot_auto) |=> (base == $past(win_line) + W'(1))); // R5
    AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        setup_start |=> (imr == '0 && isr == '0 && base == '0 && state == ST_VEC)); // R6
    AST_SPEC_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (op_word && op == OP_SPEC_EOI) |=> !isr[$past(arg_line)]); // R9

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          cmd_we,
    input  logic          cmd_re,
    input  logic [1:0]    cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic [DW-1:0] cmd_rdata,
    output logic          irq_out,
    input  logic          ack,
    output logic [DW-1:0] ack_vector
);
    localparam int W = $clog2(N);

    logic [N-1:0]    irr, imr, isr, trig, ack_clr, pend;
    logic [W-1:0]    base;
    logic [DW-W-1:0] vec_base;
    logic            read_sel, poll_armed, init_clr;
    logic            req_found, isr_found, win_valid;
    logic [W-1:0]    req_line, req_rank, isr_line, isr_rank;
    logic [DW-1:0]   poll_word;

    for (genvar i = 0; i < N; i++) begin : g_pin
        intc_pin_latch u_latch (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (irq_in[i]),
            .level_mode (trig[i]),
            .ack_clr    (ack_clr[i]),
            .init_clr   (init_clr),
            .req        (irr[i])
        );
    end

    assign pend = irr & ~imr;

    intc_prio_resolve #(.N(N)) u_req_rank (
        .bits  (pend),
        .base  (base),
        .found (req_found),
        .line  (req_line),
        .rank  (req_rank)
    );

    intc_prio_resolve #(.N(N)) u_isr_rank (
        .bits  (isr),
        .base  (base),
        .found (isr_found),
        .line  (isr_line),
        .rank  (isr_rank)
    );

    assign win_valid = req_found && (!isr_found || (req_rank < isr_rank));
    assign irq_out   = win_valid;

    intc_ctrl #(.N(N), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .cmd_re     (cmd_re),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .ack        (ack),
        .irr        (irr),
        .win_valid  (win_valid),
        .win_line   (req_line),
        .isr_found  (isr_found),
        .isr_line   (isr_line),
        .imr        (imr),
        .isr        (isr),
        .trig       (trig),
        .base       (base),
        .vec_base   (vec_base),
        .read_sel   (read_sel),
        .poll_armed (poll_armed),
        .init_clr   (init_clr),
        .ack_clr    (ack_clr)
    );

    assign ack_vector = {vec_base, win_valid ? req_line : W'(N - 1)};
    assign poll_word  = win_valid ? {1'b1, {(DW-1-W){1'b0}}, req_line} : DW'(N - 1);

    always_comb begin
        cmd_rdata = '0;
        if (poll_armed && (cmd_addr == ADDR_CMD || cmd_addr == ADDR_DATA))
            cmd_rdata = poll_word;
        else if (cmd_addr == ADDR_CMD)
            cmd_rdata = DW'(read_sel ? isr : irr);
        else if (cmd_addr == ADDR_DATA)
            cmd_rdata = DW'(imr);
        else if (cmd_addr == ADDR_TRIG)
            cmd_rdata = DW'(trig);
    end

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq_out); // R3
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_addr == ADDR_DATA && u_ctrl.state == ST_RUN) |=> (imr == $past(cmd_wdata[N-1:0]))); // R11

endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cmd_we = 1'b0;
    logic       cmd_re = 1'b0;
    logic [1:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic [7:0] cmd_rdata;
    logic       irq_out;
    logic       ack = 1'b0;
    logic [7:0] ack_vector;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_intc u_prio_intc (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cmd_we(cmd_we), .cmd_re(cmd_re), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .irq_out(irq_out), .ack(ack), .ack_vector(ack_vector)
    );

    typedef struct packed {
        logic [7:0] trig;
        logic [7:0] mask;
        logic [2:0] base;
        logic [7:0] pins;
        logic       exp_int;
        logic [2:0] line;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 3'd0, 8'h0A, 1'b1, 3'd1},
        '{8'h00, 8'h00, 3'd2, 8'h0A, 1'b1, 3'd3},
        '{8'h00, 8'h00, 3'd4, 8'h0A, 1'b1, 3'd1},
        '{8'h00, 8'h02, 3'd0, 8'h0A, 1'b1, 3'd3},
        '{8'h00, 8'hFF, 3'd0, 8'h0A, 1'b0, 3'd7},
        '{8'h00, 8'h00, 3'd5, 8'h00, 1'b0, 3'd7},
        '{8'h80, 8'h00, 3'd0, 8'h80, 1'b1, 3'd7},
        '{8'h80, 8'h00, 3'd7, 8'h81, 1'b1, 3'd7}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cmd_re = 1'b1; cmd_addr = a;
        #1 d = cmd_rdata;
        @(negedge clk);
        cmd_re = 1'b0;
    endtask

    task automatic do_ack(output logic [7:0] v);
        @(negedge clk);
        ack = 1'b1;
        #1 v = ack_vector;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic setup(input logic [7:0] vb, input logic [7:0] mode);
        wr(2'd0, 8'h11);
        wr(2'd1, vb);
        wr(2'd1, 8'h00);
        wr(2'd1, mode);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R12 reset state
        check("R12 irq_out", {7'd0, irq_out}, 8'h00);
        #1 check("R12 ack_vector", ack_vector, 8'h07);
        rd(2'd1, v); check("R12 mask", v, 8'h00);
        rd(2'd0, v); check("R12 request", v, 8'h00);

        // Table walk: R2 rotation, R3 output, R4 vector and service
        for (int i = 0; i < NV; i++) begin
            irq_in = 8'h00;
            step();
            setup(8'h20, 8'h01);
            wr(2'd2, VECS[i].trig);
            wr(2'd1, VECS[i].mask);
            wr(2'd0, 8'hC0 | {5'd0, 3'(VECS[i].base + 3'd7)});
            irq_in = VECS[i].pins;
            step();
            check($sformatf("R2/R3 vec%0d irq_out", i), {7'd0, irq_out}, {7'd0, VECS[i].exp_int});
            do_ack(v);
            check($sformatf("R4 vec%0d vector", i), v, 8'h20 | {5'd0, VECS[i].line});
            if (VECS[i].exp_int) begin
                wr(2'd0, 8'h0B);
                rd(2'd0, v);
                check($sformatf("R4 vec%0d in-service", i), v, 8'h01 << VECS[i].line);
            end
        end

        // Nesting and EOI commands: R3, R9, R1
        irq_in = 8'h00; step();
        wr(2'd2, 8'h00);
        setup(8'h20, 8'h01);
        irq_in = 8'h20; step();
        do_ack(v); check("R4 nested first", v, 8'h25);
        irq_in = 8'h60; step();
        check("R3 lower rank blocked", {7'd0, irq_out}, 8'h00);
        irq_in = 8'h64; step();
        check("R3 higher rank passes", {7'd0, irq_out}, 8'h01);
        do_ack(v); check("R4 nested second", v, 8'h22);
        wr(2'd0, 8'h0B);
        rd(2'd0, v); check("R4 two in service", v, 8'h24);
        wr(2'd0, 8'h20);
        rd(2'd0, v); check("R9 nonspecific eoi", v, 8'h20);
        check("R3 still blocked", {7'd0, irq_out}, 8'h00);
        wr(2'd0, 8'h40);
        rd(2'd0, v); check("R9 code 2 no effect", v, 8'h20);
        wr(2'd0, 8'h65);
        rd(2'd0, v); check("R9 specific eoi", v, 8'h00);
        check("R3 released", {7'd0, irq_out}, 8'h01);
        wr(2'd0, 8'h0A);
        rd(2'd0, v); check("R1 held-high edge pins not re-requested", v, 8'h40);

        // Mask register: R11
        wr(2'd1, 8'h40);
        check("R11 masked drops irq_out", {7'd0, irq_out}, 8'h00);
        rd(2'd1, v); check("R11 mask readback", v, 8'h40);
        wr(2'd1, 8'h00);
        check("R11 unmask raises irq_out", {7'd0, irq_out}, 8'h01);

        // Auto-EOI with rotation: R5
        irq_in = 8'h00; step();
        setup(8'h20, 8'h03);
        wr(2'd0, 8'h80);
        irq_in = 8'h08; step();
        do_ack(v); check("R5 first vector", v, 8'h23);
        wr(2'd0, 8'h0B);
        rd(2'd0, v); check("R5 no in-service", v, 8'h00);
        irq_in = 8'h29; step();
        do_ack(v); check("R5 rotated winner", v, 8'h25);
        do_ack(v); check("R5 rotated again", v, 8'h20);

        // Rotating commands: R10
        irq_in = 8'h00; step();
        setup(8'h20, 8'h01);
        irq_in = 8'h04; step();
        do_ack(v); check("R10 setup vector", v, 8'h22);
        wr(2'd0, 8'hA0);
        irq_in = 8'h16; step();
        do_ack(v); check("R10 code 5 rotation", v, 8'h24);
        wr(2'd0, 8'hE4);
        irq_in = 8'h1E; step();
        do_ack(v); check("R10 code 7 rotation", v, 8'h21);

        // Poll: R7, R8
        irq_in = 8'h00; step();
        setup(8'h20, 8'h01);
        irq_in = 8'h10; step();
        wr(2'd0, 8'h0C);
        rd(2'd0, v); check("R8 poll word", v, 8'h84);
        wr(2'd0, 8'h0B);
        rd(2'd0, v); check("R8 poll acknowledged", v, 8'h10);
        wr(2'd0, 8'h0C);
        rd(2'd1, v); check("R8 poll empty", v, 8'h07);
        rd(2'd1, v); check("R7 poll one shot", v, 8'h00);

        // Setup sequence: R6
        wr(2'd1, 8'h55);
        irq_in = 8'h00; step();
        wr(2'd0, 8'h11);
        rd(2'd1, v); check("R6 mask cleared", v, 8'h00);
        wr(2'd1, 8'h48);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h01);
        rd(2'd0, v); check("R6 request cleared", v, 8'h00);
        wr(2'd0, 8'h0B);
        rd(2'd0, v); check("R6 in-service cleared", v, 8'h00);
        irq_in = 8'h01; step();
        do_ack(v); check("R6 vector base", v, 8'h48);
        irq_in = 8'h00; step();
        wr(2'd0, 8'h13);
        wr(2'd1, 8'h50);
        wr(2'd1, 8'h02);
        wr(2'd1, 8'hF0);
        rd(2'd1, v); check("R6 single skips link byte", v, 8'hF0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule